// File: doc/BRIEF.md
# Second-level interrupt router with forwarding bypass

This block gathers a word of peripheral interrupt sources into a single pending-status register. It gates the status with an enable register and distributes the result over several parent interrupt lines. Each parent has a static map mask, so one source may reach one parent, several parents or none.

A static forward mask picks sources that do not use the controller at all. Those inputs go straight to a dedicated output vector. They never set a status bit and never reach a parent line.

Software sees two registers whose offsets are parameters. Either register may sit at the lower address. The enable register is written directly. The status register is cleared by writing ones to it. Sources marked as wake-capable keep their pending bit through reset, so the event that caused a resume can still be read after it.

Top module: `irq_l2_router`

## Requirements
- R1: While reset is applied, and in the first cycle after it, the enable register reads 0 and every parent output is 0.
- R2: A write at offset EN_OFS (default 0x00) loads the enable register, and a read there returns it. A read at ST_OFS (default 0x04) returns the status register. Any other offset reads 0. The two offsets are independent, and ST_OFS may be below EN_OFS.
- R3: A rising edge on a non-forwarded source sets its status bit at the clock edge that samples the high level, whatever the enable register holds.
- R4: Writing 1 to a status bit at ST_OFS clears it when its source is low. Writing 0 leaves the bit unchanged.
- R5: A status bit that is cleared while its source is still high stays set.
- R6: A rising edge on a source in the same cycle as a write-1 clear of its bit leaves the bit set.
- R7: Parent output k is registered. It equals the OR of status AND enable AND map mask k, and follows a change of enable or status one clock later. Default masks are 0x0000FFFF for parent 0 and 0xFF00FF00 for parent 1.
- R8: A source whose forward-mask bit is set (default bits 0 and 31) appears combinationally on fwd_irq at its bit position. It never sets its status bit and never drives a parent. fwd_irq is 0 at every other bit.
- R9: Reset clears the status bits outside the wake mask (default bits 4 and 5). It keeps the bits inside the wake mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NSRC | Peripheral interrupt levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, combinational from bus_addr |
| par_irq | output | NPAR | Registered parent interrupt lines |
| fwd_irq | output | NSRC | Bypassed sources |

## Verification
Two events can fall in the same cycle: a software write-1 clear and a fresh rising edge on the same source. The bench first makes the bit pending and drops the source. Then, on one falling clock edge, it raises the source again and issues the clear. The status read that follows must still show the bit set. A second collision is also checked: a clear while the source is still held high must not drop the bit.

// File: rtl/irq_l2_router.sv
module irq_l2_router #(
  parameter int NSRC = 32,
  parameter int NPAR = 2,
  parameter int AW = 8,
  parameter logic [AW-1:0] EN_OFS = 8'h00,
  parameter logic [AW-1:0] ST_OFS = 8'h04,
  parameter logic [NPAR*NSRC-1:0] MAP_MASKS = {32'hFF00_FF00, 32'h0000_FFFF},
  parameter logic [NSRC-1:0] FWD_MASK = 32'h8000_0001,
  parameter logic [NSRC-1:0] WAKE_MASK = 32'h0000_0030
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic [NPAR-1:0] par_irq,
  output logic [NSRC-1:0] fwd_irq
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] stat_q = '0;
  logic [NSRC-1:0] src_q = '0;
  logic [NSRC-1:0] rise, clr, stat_n;
  logic [NPAR-1:0] par_q;
  logic wr_en, wr_st;

  initial assert (EN_OFS != ST_OFS);

  assign wr_en = bus_wr && (bus_addr == EN_OFS);
  assign wr_st = bus_wr && (bus_addr == ST_OFS);
  assign rise  = src_i & ~src_q & ~FWD_MASK;
  assign clr   = wr_st ? (bus_wdata & ~src_i) : '0;
  assign stat_n = (stat_q & ~clr) | rise;

  assign fwd_irq = src_i & FWD_MASK;
  assign par_irq = par_q;
  assign bus_rdata = (bus_addr == EN_OFS) ? en_q :
                     (bus_addr == ST_OFS) ? stat_q : '0;

  always_ff @(posedge clk) src_q <= src_i;

  always_ff @(posedge clk)
    if (!rst_n) stat_q <= stat_n & WAKE_MASK;
    else        stat_q <= stat_n;

  always_ff @(posedge clk)
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= bus_wdata;

  for (genvar k = 0; k < NPAR; k++) begin : g_par
    localparam logic [NSRC-1:0] MK = MAP_MASKS[k*NSRC +: NSRC] & ~FWD_MASK;
    always_ff @(posedge clk)
      if (!rst_n) par_q[k] <= 1'b0;
      else        par_q[k] <= |(stat_q & en_q & MK);

    AST_PAR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      par_q[k] |-> |($past(stat_q) & MK)); // R7
  end

  AST_EN_RESET: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && par_q == '0)); // R1

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata))); // R2

  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((stat_q & $past(bus_wdata & ~src_i)) == '0)); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5

  AST_FWD_NO_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & FWD_MASK) == '0); // R8

endmodule

// File: tb/irq_l2_router_bench.sv
module irq_l2_router_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [31:0] src_i = '0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, fwd_irq, rdata2, fwd2;
  logic [1:0] par_irq, par2;

  always #2.5 clk = ~clk;

  irq_l2_router u_irq_l2_router (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .par_irq(par_irq), .fwd_irq(fwd_irq));

  irq_l2_router #(.EN_OFS(8'h14), .ST_OFS(8'h10)) u_irq_l2_router_swp (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .par_irq(par2), .fwd_irq(fwd2));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {30'd0, par_irq};
        2: act = fwd_irq;
        default: act = rdata2;
      endcase
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag, int kind = 0);
    bus_addr = a;
    push(kind, exp, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd(8'h00, 32'h0, "R1 enable in reset");
    push(1, 32'h0, "R1 parents in reset");
    rst_n = 1;
    rd(8'h00, 32'h0, "R1 enable after reset");
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, 32'hA5A5_0F0F, "R2 enable readback");
    rd(8'h08, 32'h0, "R2 unmapped offset");
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, 32'h1234_5678, "R2 swapped enable offset", 3);
    rd(8'h10, 32'h0, "R2 swapped status offset", 3);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'h0);
    src_i[2] = 1;
    @(negedge clk);
    rd(8'h04, 32'h4, "R3 edge latched with enable off");
    push(1, 32'h0, "R7 gated by enable");
    wr(8'h00, 32'h4);
    push(1, 32'h0, "R7 one cycle latency");
    push(1, 32'h1, "R7 parent0 only");
    wr(8'h04, 32'h4);
    rd(8'h04, 32'h4, "R5 clear while high");
    src_i[2] = 0;
    @(negedge clk);
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h4, "R4 write zero no effect");
    wr(8'h04, 32'h4);
    rd(8'h04, 32'h0, "R4 clear when low");
    push(1, 32'h0, "R7 parent drops");
    src_i[9] = 1; @(negedge clk);
    src_i[9] = 0; @(negedge clk);
    src_i[9] = 1;
    wr(8'h04, 32'h200);
    rd(8'h04, 32'h200, "R6 edge with clear");
    wr(8'h00, 32'h200);
    @(negedge clk);
    push(1, 32'h3, "R7 overlapping maps");
    src_i[9] = 0;
    wr(8'h04, 32'h200);
    wr(8'h00, 32'h8000_0001);
    src_i[0] = 1;
    push(2, 32'h1, "R8 forward visible");
    src_i[31] = 1;
    @(negedge clk);
    rd(8'h04, 32'h0, "R8 no status for forwarded");
    push(1, 32'h0, "R8 no parent for forwarded");
    push(2, 32'h8000_0001, "R8 forward vector");
    src_i[0] = 0; src_i[31] = 0;
    src_i[4] = 1; src_i[6] = 1; @(negedge clk);
    src_i[4] = 0; src_i[6] = 0; @(negedge clk);
    rd(8'h04, 32'h50, "R9 pending before reset");
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(8'h04, 32'h10, "R9 wake bit kept");
    rd(8'h00, 32'h0, "R1 enable cleared by reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule